// File: doc/BRIEF.md
# GCR Floppy Sector Encoder

This block turns one logical sector into the byte stream that a drive model writes onto a 3.5-inch disk track. It uses group-coded recording (GCR). A one-cycle start pulse latches four 6-bit header fields: track, sector, side and format. The encoder then emits the following, in order:

- a lead run of $FF sync bytes;
- the address block;
- a gap run of $FF sync bytes;
- the data block, which holds the translated sector number, the mixed and packed payload, and a four-nibble checksum.

Every byte goes out through a valid/ready handshake, so the consumer sets the pace.

The payload is fetched through a read port that returns three consecutive sector bytes per group index. Before translation, each byte is XOR-mixed with one of three running sums, one per position in its group. Those sums are chained by carries and rotated once per group. Each group of three mixed bytes becomes four 6-bit nibbles. Every nibble passes through a 64-entry table of disk-safe codes that is computed at elaboration.

Top module: `gcr_sector_enc`

## Requirements
- R1: After reset, out_valid and done are low and the encoder waits for start.
- R2: A start pulse while idle begins a frame whose first LEAD_SYNC bytes are $FF. A start pulse while a frame is in progress is ignored and the frame continues unchanged.
- R3: The address block is $D5 $AA $96, then the translated track, sector, side and format fields, then the translated XOR of those four fields, then $DE $AA $FF.
- R4: After the address block come GAP_SYNC bytes of $FF, then $D5 $AA $AD, then the translated sector field.
- R5: Translation maps index i to the i-th byte, in ascending order, among values with bit 7 set, at most one pair of adjacent zero bits, and at least one pair of adjacent one bits within bits 6..0. Index 0 gives $96 and index 63 gives $FF.
- R6: The three 8-bit sums s0, s1, s2 start at zero. For a group (b0,b1,b2), let r = s2[7] and s2r = s2 rotated left by one bit. The mixed bytes are b0^s0, b1^s1 and b2^s2r. The new sums are s0+b0+r, s1+b1+carry0 and s2r+b2+carry1, each kept to 8 bits, where carryN is the carry out of the preceding addition.
- R7: Each group emits four nibbles: {m0[7:6],m1[7:6],m2[7:6]}, then m0[5:0], m1[5:0] and m2[5:0], each translated.
- R8: rd_word holds byte 3·rd_addr in bits 23:16, the next byte in bits 15:8 and the one after that in bits 7:0. Any byte whose index is SECTOR_BYTES or greater is taken as zero, whatever rd_word carries.
- R9: After the last group, the final sums (s0,s1,s2) are emitted packed and translated as in R7, then $DE $AA $FF.
- R10: A byte transfers on a clock edge where out_valid and out_ready are both high. While out_ready is low, out_valid and out_byte hold.
- R11: done is high for exactly one cycle, the cycle after the last trailer byte transfers. In that cycle out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| trk_field | input | 6 | Track header field |
| sec_field | input | 6 | Sector header field |
| side_field | input | 6 | Side header field |
| fmt_field | input | 6 | Format header field |
| rd_addr | output | clog2(groups) | Group index of the payload fetch |
| rd_word | input | 24 | Three payload bytes of the addressed group |
| out_byte | output | 8 | Disk byte |
| out_valid | output | 1 | out_byte is valid |
| out_ready | input | 1 | Consumer accepts out_byte |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench builds the encoder with a 7-byte sector, 4 lead sync bytes and 3 gap sync bytes, so each frame is 41 bytes long. With 7 bytes, the last group carries two pad positions. The read model returns $A5 in those positions, so the zero padding and the carry chain through a partial group both show up in the checksum nibbles. The short frames leave room to repeat the encode with several stall patterns, with a start pulse injected mid-frame, and with header fields at the table extremes 0 and 63.

// File: rtl/gcr_enc_pkg.sv
package gcr_enc_pkg;

  typedef logic [7:0] gcr_tbl_t [64];

  typedef struct packed {
    logic [7:0] s0;
    logic [7:0] s1;
    logic [7:0] s2;
  } sums_t;

  typedef struct packed {
    logic [23:0] mixed;
    sums_t       nxt;
  } mix_t;

  // A code is disk-safe when the top bit is set, adjacent zeros occur at
  // most once and some adjacent pair of ones lies below bit 7.
  function automatic logic disk_safe(input logic [7:0] v);
    int   zpairs;
    logic ones;
    zpairs = 0;
    ones   = 1'b0;
    for (int i = 0; i < 7; i++) begin
      if (!v[i] && !v[i+1]) zpairs++;
      if (i < 6 && v[i] && v[i+1]) ones = 1'b1;
    end
    return v[7] && (zpairs <= 1) && ones;
  endfunction

  function automatic gcr_tbl_t build_tbl();
    gcr_tbl_t t;
    int       n;
    n = 0;
    for (int i = 0; i < 64; i++) t[i] = 8'hFF;
    for (int v = 128; v < 256; v++) begin
      if (n < 64 && disk_safe(v[7:0])) begin
        t[n] = v[7:0];
        n++;
      end
    end
    return t;
  endfunction

  // One group step: mix against the old sums, then chain the carries.
  function automatic mix_t mix_group(input sums_t c, input logic [23:0] b);
    mix_t       m;
    logic       r;
    logic [7:0] c2r;
    logic [8:0] t0, t1, t2;
    r   = c.s2[7];
    c2r = {c.s2[6:0], c.s2[7]};
    t0  = {1'b0, c.s0} + {1'b0, b[23:16]} + {8'd0, r};
    t1  = {1'b0, c.s1} + {1'b0, b[15:8]}  + {8'd0, t0[8]};
    t2  = {1'b0, c2r}  + {1'b0, b[7:0]}   + {8'd0, t1[8]};
    m.mixed = {b[23:16] ^ c.s0, b[15:8] ^ c.s1, b[7:0] ^ c2r};
    m.nxt   = '{s0: t0[7:0], s1: t1[7:0], s2: t2[7:0]};
    return m;
  endfunction

  // Nibble 0 packs the top bit pairs; nibbles 1..3 carry the low six bits.
  function automatic logic [5:0] pack_nib(input logic [23:0] w, input logic [1:0] pos);
    unique case (pos)
      2'd0:    return {w[23:22], w[15:14], w[7:6]};
      2'd1:    return w[21:16];
      2'd2:    return w[13:8];
      default: return w[5:0];
    endcase
  endfunction

endpackage

// File: rtl/gcr_nib_xlat.sv
module gcr_nib_xlat
  import gcr_enc_pkg::*;
(
  input  logic [5:0] nib,
  output logic [7:0] code
);
  localparam gcr_tbl_t TBL = build_tbl();

  assign code = TBL[nib];

  // R5
  always_comb begin
    code_msb_chk: assert (code[7] == 1'b1);
  end
endmodule

// File: rtl/gcr_mix_acc.sv
module gcr_mix_acc
  import gcr_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        advance,
  input  logic [23:0] grp_in,
  output logic [23:0] mixed_out,
  output logic [23:0] sums_out
);
  sums_t acc;
  mix_t  step;

  assign step      = mix_group(acc, grp_in);
  assign mixed_out = step.mixed;
  assign sums_out  = acc;

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (clear)   acc <= '0;
    else if (advance) acc <= step.nxt;
  end

  // R6
  sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sums_out == 24'd0));

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(sums_out));
endmodule

// File: rtl/gcr_sector_enc.sv
module gcr_sector_enc
  import gcr_enc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LEAD_SYNC    = 16,
  parameter int GAP_SYNC     = 6,
  localparam int GROUPS      = (SECTOR_BYTES + 2) / 3,
  localparam int AW          = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    trk_field,
  input  logic [5:0]    sec_field,
  input  logic [5:0]    side_field,
  input  logic [5:0]    fmt_field,
  output logic [AW-1:0] rd_addr,
  input  logic [23:0]   rd_word,
  output logic [7:0]    out_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          done
);
  localparam int CNT_W = $clog2(LEAD_SYNC + GAP_SYNC + 8);

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_AMARK, PH_AFIELD, PH_ATRAIL, PH_GAP,
    PH_DHEAD, PH_DSEC, PH_DPAY, PH_DSUM, PH_DTRAIL
  } ph_t;

  ph_t              ph, nxt_ph;
  logic [CNT_W-1:0] idx;
  logic [1:0]       pos;
  logic [AW-1:0]    grp;
  logic [5:0]       f_trk, f_sec, f_side, f_fmt;
  logic             last_byte, fire, start_acc, grp_end;
  logic             coded;
  logic [5:0]       nib;
  logic [7:0]       lit, code;
  logic [23:0]      grp_bytes, mixed, sums;

  assign out_valid = (ph != PH_IDLE);
  assign fire      = out_valid && out_ready;
  assign start_acc = (ph == PH_IDLE) && start;
  assign grp_end   = fire && (ph == PH_DPAY) && (pos == 2'd3);
  assign rd_addr   = grp;

  // Lanes past the end of the sector read as zero.
  for (genvar k = 0; k < 3; k++) begin : g_lane
    logic lane_ok;
    assign lane_ok = (32'(grp) * 32'd3 + 32'(k)) < 32'(SECTOR_BYTES);
    assign grp_bytes[23-8*k -: 8] = lane_ok ? rd_word[23-8*k -: 8] : 8'h00;
  end

  gcr_mix_acc u_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_acc),
    .advance  (grp_end),
    .grp_in   (grp_bytes),
    .mixed_out(mixed),
    .sums_out (sums)
  );

  gcr_nib_xlat u_xlat (
    .nib (nib),
    .code(code)
  );

  always_comb begin
    last_byte = 1'b0;
    nxt_ph    = PH_IDLE;
    unique case (ph)
      PH_LEAD:   begin last_byte = (idx == CNT_W'(LEAD_SYNC - 1)); nxt_ph = PH_AMARK;  end
      PH_AMARK:  begin last_byte = (idx == CNT_W'(2));             nxt_ph = PH_AFIELD; end
      PH_AFIELD: begin last_byte = (idx == CNT_W'(4));             nxt_ph = PH_ATRAIL; end
      PH_ATRAIL: begin last_byte = (idx == CNT_W'(2));             nxt_ph = PH_GAP;    end
      PH_GAP:    begin last_byte = (idx == CNT_W'(GAP_SYNC - 1));  nxt_ph = PH_DHEAD;  end
      PH_DHEAD:  begin last_byte = (idx == CNT_W'(2));             nxt_ph = PH_DSEC;   end
      PH_DSEC:   begin last_byte = 1'b1;                           nxt_ph = PH_DPAY;   end
      PH_DPAY:   begin
        last_byte = (grp == AW'(GROUPS - 1)) && (pos == 2'd3);
        nxt_ph    = PH_DSUM;
      end
      PH_DSUM:   begin last_byte = (pos == 2'd3);                  nxt_ph = PH_DTRAIL; end
      PH_DTRAIL: begin last_byte = (idx == CNT_W'(2));             nxt_ph = PH_IDLE;   end
      default:   begin last_byte = 1'b0;                           nxt_ph = PH_IDLE;   end
    endcase
  end

  always_comb begin
    coded = 1'b0;
    nib   = 6'd0;
    lit   = 8'hFF;
    unique case (ph)
      PH_AMARK, PH_DHEAD: begin
        unique case (idx[1:0])
          2'd0:    lit = 8'hD5;
          2'd1:    lit = 8'hAA;
          default: lit = (ph == PH_AMARK) ? 8'h96 : 8'hAD;
        endcase
      end
      PH_ATRAIL, PH_DTRAIL: begin
        unique case (idx[1:0])
          2'd0:    lit = 8'hDE;
          2'd1:    lit = 8'hAA;
          default: lit = 8'hFF;
        endcase
      end
      PH_AFIELD: begin
        coded = 1'b1;
        unique case (idx[2:0])
          3'd0:    nib = f_trk;
          3'd1:    nib = f_sec;
          3'd2:    nib = f_side;
          3'd3:    nib = f_fmt;
          default: nib = f_trk ^ f_sec ^ f_side ^ f_fmt;
        endcase
      end
      PH_DSEC: begin coded = 1'b1; nib = f_sec;                end
      PH_DPAY: begin coded = 1'b1; nib = pack_nib(mixed, pos); end
      PH_DSUM: begin coded = 1'b1; nib = pack_nib(sums, pos);  end
      default: lit = 8'hFF;
    endcase
  end

  assign out_byte = coded ? code : lit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      idx    <= '0;
      pos    <= '0;
      grp    <= '0;
      done   <= 1'b0;
      f_trk  <= '0;
      f_sec  <= '0;
      f_side <= '0;
      f_fmt  <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        ph     <= PH_LEAD;
        idx    <= '0;
        pos    <= '0;
        grp    <= '0;
        f_trk  <= trk_field;
        f_sec  <= sec_field;
        f_side <= side_field;
        f_fmt  <= fmt_field;
      end else if (fire) begin
        if (ph == PH_DPAY || ph == PH_DSUM) pos <= pos + 2'd1;
        if (grp_end && !last_byte) grp <= grp + AW'(1);
        if (last_byte) begin
          ph  <= nxt_ph;
          idx <= '0;
          if (ph == PH_DTRAIL) done <= 1'b1;
        end else begin
          idx <= idx + CNT_W'(1);
        end
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LEAD && $past(ph) != PH_LEAD) |-> ($past(ph) == PH_IDLE));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !$past(done)));

  // R8
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DPAY) |-> (32'(rd_addr) < 32'(GROUPS)));

  // R7
  coded_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && coded) |-> out_byte[7]);
endmodule

// File: tb/gcr_sector_enc_bench.sv
module gcr_sector_enc_bench;
  localparam int N    = 7;
  localparam int LEAD = 4;
  localparam int GAP  = 3;
  localparam int GRP  = (N + 2) / 3;
  localparam int AW   = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int ADDR_AT = LEAD;
  localparam int PAY_AT  = LEAD + 11 + GAP + 4;
  localparam int SUM_AT  = PAY_AT + 4 * GRP;
  localparam int TOTAL   = SUM_AT + 4 + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [5:0]    trk_field = '0, sec_field = '0, side_field = '0, fmt_field = '0;
  logic [AW-1:0] rd_addr;
  logic [23:0]   rd_word;
  logic [7:0]    out_byte;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          done;

  logic [7:0] mem [N];
  logic [7:0] expb [64];
  logic [7:0] cap [64];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gcr_sector_enc #(.SECTOR_BYTES(N), .LEAD_SYNC(LEAD), .GAP_SYNC(GAP)) u_gcr_sector_enc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .trk_field(trk_field), .sec_field(sec_field), .side_field(side_field), .fmt_field(fmt_field),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  // Read model: bytes past the sector return a marker that must not leak.
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      int bi;
      bi = int'(rd_addr) * 3 + k;
      rd_word[23-8*k -: 8] = (bi < N) ? mem[bi] : 8'hA5;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles (expected frame completion)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, want);
    end
  endtask

  // Table restated: walk candidates, keep the wanted ordinal.
  function automatic logic [7:0] ref_code(input int sel);
    int n;
    n = 0;
    for (int v = 128; v < 256; v++) begin
      int zp;
      bit one;
      zp = 0;
      one = 0;
      for (int i = 0; i < 7; i++) begin
        if (((v >> i) & 3) == 0) zp++;
        if (i < 6 && ((v >> i) & 3) == 3) one = 1;
      end
      if (zp <= 1 && one) begin
        if (n == sel) return 8'(v);
        n++;
      end
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(input int p);
    if (p < LEAD) return "R2";
    if (p < LEAD + 11) return "R3";
    if (p < PAY_AT) return "R4";
    if (p < SUM_AT) return "R6/R7/R8";
    return "R9";
  endfunction

  task automatic build_expected(input int t, input int s, input int sd, input int f);
    int n, a0, a1, a2, r, c2r, x;
    int b [3];
    int m [3];
    n = 0;
    for (int i = 0; i < LEAD; i++) expb[n++] = 8'hFF;
    expb[n++] = 8'hD5; expb[n++] = 8'hAA; expb[n++] = 8'h96;
    expb[n++] = ref_code(t); expb[n++] = ref_code(s);
    expb[n++] = ref_code(sd); expb[n++] = ref_code(f);
    expb[n++] = ref_code(t ^ s ^ sd ^ f);
    expb[n++] = 8'hDE; expb[n++] = 8'hAA; expb[n++] = 8'hFF;
    for (int i = 0; i < GAP; i++) expb[n++] = 8'hFF;
    expb[n++] = 8'hD5; expb[n++] = 8'hAA; expb[n++] = 8'hAD;
    expb[n++] = ref_code(s);
    a0 = 0; a1 = 0; a2 = 0;
    for (int g = 0; g < GRP; g++) begin
      for (int k = 0; k < 3; k++) b[k] = (3 * g + k < N) ? int'(mem[3 * g + k]) : 0;
      r   = a2 / 128;
      c2r = ((a2 * 2) % 256) + r;
      m[0] = b[0] ^ a0; m[1] = b[1] ^ a1; m[2] = b[2] ^ c2r;
      x = a0 + b[0] + r;    a0 = x % 256;
      x = a1 + b[1] + x / 256; a1 = x % 256;
      x = c2r + b[2] + x / 256; a2 = x % 256;
      expb[n++] = ref_code((m[0] / 64) * 16 + (m[1] / 64) * 4 + m[2] / 64);
      for (int k = 0; k < 3; k++) expb[n++] = ref_code(m[k] % 64);
    end
    expb[n++] = ref_code((a0 / 64) * 16 + (a1 / 64) * 4 + a2 / 64);
    expb[n++] = ref_code(a0 % 64);
    expb[n++] = ref_code(a1 % 64);
    expb[n++] = ref_code(a2 % 64);
    expb[n++] = 8'hDE; expb[n++] = 8'hAA; expb[n++] = 8'hFF;
  endtask

  // mode 0: always ready, 1: every other cycle, 2: two of three cycles
  task automatic run_frame(input int t, input int s, input int sd, input int f,
                           input int mode, input bit poke);
    int got, dones;
    bit stalled, finished;
    logic [7:0] held;
    build_expected(t, s, sd, f);
    @(negedge clk);
    trk_field = 6'(t); sec_field = 6'(s); side_field = 6'(sd); fmt_field = 6'(f);
    start = 1'b1;
    got = 0; dones = 0; stalled = 0; finished = 0; held = 8'h00;
    for (int cyc = 0; cyc < 600 && !finished; cyc++) begin
      @(negedge clk);
      start = (poke && cyc == 10) ? 1'b1 : 1'b0;
      if (done) begin
        dones++;
        check("R11 valid low with done", {31'd0, out_valid}, 32'd0);
        finished = 1;
      end else begin
        if (stalled) check("R10 hold while stalled", {24'd0, out_byte}, {24'd0, held});
        case (mode)
          0: out_ready = 1'b1;
          1: out_ready = cyc[0];
          default: out_ready = (cyc % 3) != 0;
        endcase
        stalled = out_valid && !out_ready;
        held = out_byte;
        if (out_valid && out_ready && got < 64) begin
          cap[got] = out_byte;
          check(tag_of(got), {24'd0, out_byte}, {24'd0, expb[got]});
          got++;
        end
      end
    end
    check("R11 frame byte count", 32'(got), 32'(TOTAL));
    check("R11 done seen", 32'(dones), 32'd1);
    @(negedge clk);
    check("R11 done is one pulse", {31'd0, done}, 32'd0);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 done after reset", {31'd0, done}, 32'd0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < N; i++) mem[i] = 8'(i * 37 + 5);
    run_frame(5, 9, 1, 34, 0, 0);
  endtask

  task automatic t_stall_ones();
    for (int i = 0; i < N; i++) mem[i] = 8'hFF;
    run_frame(62, 3, 0, 2, 1, 0);
    run_frame(17, 44, 1, 34, 2, 0);
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < N; i++) mem[i] = 8'(200 - i * 11);
    run_frame(7, 21, 1, 34, 0, 1);
  endtask

  task automatic t_table_ends();
    for (int i = 0; i < N; i++) mem[i] = 8'h80;
    run_frame(0, 63, 0, 0, 0, 0);
    check("R5 index 0 code", {24'd0, cap[ADDR_AT + 3]}, 32'h96);
    check("R5 index 63 code", {24'd0, cap[ADDR_AT + 4]}, 32'hFF);
    check("R5 table count", {24'd0, ref_code(63)}, 32'hFF);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stall_ones();
    t_busy_start();
    t_table_ends();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule